// File: doc/BRIEF.md
# Host Controller Interrupt Status and Mask Unit

This block holds the interrupt registers of a bus host controller. Single-cycle event pulses from the controller core are caught in a sticky status register. Software acknowledges an event by writing a one to its status bit. The mask is never written directly. It is changed through two write ports: one only sets bits and the other only clears them. Both ports read back the current mask. One interrupt line leaves the block, and the top bit of the mask acts as a global gate on it.

Register access goes through a plain 32-bit port with word offsets. Writes take effect on the clock edge. Read data is a combinational function of the offset and the current register contents. The defined sources are these: scheduling overrun (bit 0), done-queue write-back (bit 1), frame start (bit 2), resume detected (bit 3), fatal error (bit 4), frame counter wrap (bit 5), hub port change (bit 6) and ownership handover (bit 30).

Top module: `hc_irq_regs`

## Requirements
- R1: A pulse on `evt_i[k]` for a defined source position k (0 to 6, or 30) sets status bit k at the next clock edge. The bit then stays set until software clears it.
- R2: A write to offset 0 (status) clears every status bit whose data bit is 1. Bits written with 0 are left unchanged.
- R3: If an event and a status clear hit the same bit in one cycle, the bit ends up set.
- R4: A write to offset 1 (mask-set) sets every mask bit whose data bit is 1. Bits written with 0 are left unchanged.
- R5: A write to offset 2 (mask-clear) clears every mask bit whose data bit is 1. Bits written with 0 are left unchanged.
- R6: A read at offset 1 and a read at offset 2 both return the current mask. A read at offset 0 returns the status.
- R7: `irq_o` is 1 exactly when mask bit 31 is 1 and, for at least one bit position from 0 to 30, both the status bit and the mask bit are 1.
- R8: Undefined positions ignore writes and events and always read 0. For the status these are bits 7 to 29 and bit 31; for the mask they are bits 7 to 29. Offset 3 reads 0, and a write to it has no effect.
- R9: After a synchronous reset the status and the mask are all zero, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Word offset of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_i | input | 31 | Event pulses for source positions 0 to 30 |
| irq_o | output | 1 | Interrupt request |

## Verification
A status bit that is lost or sticks wrongly shows in the status read at offset 0 on the cycle after the event or the clear. If its mask bit and the gate bit are set, `irq_o` moves at the same time. A mask bit that is corrupted shows at once at both mask offsets. It also flips `irq_o` as soon as a matching status bit is set. Because read data is combinational, every wrong register state can be seen on the first cycle after the edge that caused it. The bench therefore compares a register model against all three offsets and `irq_o` after every stimulus.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int SRC_N      = REG_W - 1;
    localparam int MASTER_BIT = REG_W - 1;

    // defined source positions
    localparam int SRC_SCHED_OVR = 0;
    localparam int SRC_DONE_WB   = 1;
    localparam int SRC_FRM_START = 2;
    localparam int SRC_RESUME    = 3;
    localparam int SRC_FATAL     = 4;
    localparam int SRC_FRM_WRAP  = 5;
    localparam int SRC_HUB_CHG   = 6;
    localparam int SRC_OWN_CHG   = 30;

    localparam logic [REG_W-1:0] SRC_DEF =
        (REG_W'(1) << SRC_SCHED_OVR) | (REG_W'(1) << SRC_DONE_WB) |
        (REG_W'(1) << SRC_FRM_START) | (REG_W'(1) << SRC_RESUME)  |
        (REG_W'(1) << SRC_FATAL)     | (REG_W'(1) << SRC_FRM_WRAP) |
        (REG_W'(1) << SRC_HUB_CHG)   | (REG_W'(1) << SRC_OWN_CHG);

    localparam logic [REG_W-1:0] MASK_DEF = SRC_DEF | (REG_W'(1) << MASTER_BIT);

    typedef enum logic [ADDR_W-1:0] {
        OFS_STATUS = 2'd0,
        OFS_EN_SET = 2'd1,
        OFS_EN_CLR = 2'd2,
        OFS_NONE   = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic status_clr;
        logic mask_set;
        logic mask_clr;
    } wr_sel_t;

    function automatic logic [REG_W-1:0] keep_defined(input logic [REG_W-1:0] v,
                                                      input logic [REG_W-1:0] def);
        return v & def;
    endfunction

endpackage

// File: rtl/hc_irq_decode.sv
module hc_irq_decode
    import hc_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_ofs_e          ofs,
    output wr_sel_t           sel
);
    always_comb begin
        ofs            = reg_ofs_e'(addr);
        sel            = '0;
        sel.status_clr = wr && (ofs == OFS_STATUS);
        sel.mask_set   = wr && (ofs == OFS_EN_SET);
        sel.mask_clr   = wr && (ofs == OFS_EN_CLR);
    end
endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status
    import hc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_bits,
    input  logic [REG_W-1:0] evt,
    output logic [REG_W-1:0] status_q
);
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status_d;

    always_comb begin
        clr_vec  = clr_en ? clr_bits : '0;
        status_d = keep_defined((status_q & ~clr_vec) | evt, SRC_DEF);
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && ((clr_bits & ~evt) != '0)) |=> ((status_q & $past(clr_bits & ~evt)) == '0));
    // R3
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt & SRC_DEF) != '0) |=> ((status_q & $past(evt & SRC_DEF)) == $past(evt & SRC_DEF)));
    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_en && evt == '0) |=> $stable(status_q));
endmodule

// File: rtl/hc_irq_mask.sv
module hc_irq_mask
    import hc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] bits,
    output logic [REG_W-1:0] mask_q
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        set_vec = set_en ? keep_defined(bits, MASK_DEF) : '0;
        clr_vec = clr_en ? bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | set_vec) & ~clr_vec;
    end

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((mask_q & $past(bits & MASK_DEF)) == $past(bits & MASK_DEF)));
    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((mask_q & $past(bits)) == '0));
    // R8
    mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
    import hc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [SRC_N-1:0]  evt_i,
    output logic              irq_o
);
    reg_ofs_e         ofs;
    wr_sel_t          sel;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;

    hc_irq_decode u_decode (
        .addr (reg_addr),
        .wr   (reg_wr),
        .ofs  (ofs),
        .sel  (sel)
    );

    hc_irq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (sel.status_clr),
        .clr_bits (reg_wdata),
        .evt      ({1'b0, evt_i}),
        .status_q (status_q)
    );

    hc_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (sel.mask_set),
        .clr_en (sel.mask_clr),
        .bits   (reg_wdata),
        .mask_q (mask_q)
    );

    always_comb begin
        case (ofs)
            OFS_STATUS: reg_rdata = status_q;
            OFS_EN_SET,
            OFS_EN_CLR: reg_rdata = mask_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o = mask_q[MASTER_BIT] & (|(status_q[SRC_N-1:0] & mask_q[SRC_N-1:0]));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_q[MASTER_BIT] && ((status_q & mask_q & SRC_DEF) != '0)));
    // R8
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status_q == '0 && mask_q == '0));
endmodule

// File: tb/hc_irq_regs_tb.sv
module hc_irq_regs_tb;
    localparam logic [31:0] DEF  = 32'h4000_007F;
    localparam logic [31:0] MDEF = 32'hC000_007F;

    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [30:0] evt_i = 0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_status = 0;
    logic [31:0] m_mask = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    bit done = 0;

    always #5 clk = ~clk;

    hc_irq_regs u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clocked operation; the model follows the requirements
    task automatic tick(input logic [1:0] a, input logic w, input logic [31:0] d, input logic [30:0] e);
        logic [31:0] ev;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; evt_i = e;
        ev = {1'b0, e} & DEF;
        if (w && a == 2'd0) m_status = m_status & ~d;
        m_status = (m_status | ev) & DEF;
        if (w && a == 2'd1) m_mask = m_mask | (d & MDEF);
        if (w && a == 2'd2) m_mask = m_mask & ~d;
        @(posedge clk);
        #1;
        reg_wr = 0; evt_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        logic exp_irq;
        rd(2'd0, v); chk({tag, " R6 status"}, v, m_status);
        rd(2'd1, v); chk({tag, " R6 mask@1"}, v, m_mask);
        rd(2'd2, v); chk({tag, " R6 mask@2"}, v, m_mask);
        rd(2'd3, v); chk({tag, " R8 hole"}, v, 32'h0);
        exp_irq = m_mask[31] & (|(m_status[30:0] & m_mask[30:0]));
        chk({tag, " R7 irq"}, {31'b0, irq_o}, {31'b0, exp_irq});
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int pos[8] = '{0, 1, 2, 3, 4, 5, 6, 30};
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9 reset state
        check_all("R9 reset");

        // R1 R7 sweep: each source, master off/on, mask bit on
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 8; i++) begin
                tick(2'd0, 1, 32'hFFFF_FFFF, 0);
                tick(2'd2, 1, 32'hFFFF_FFFF, 0);
                tick(2'd1, 1, (32'h1 << pos[i]) | (m[0] ? 32'h8000_0000 : 0), 0);
                tick(2'd3, 0, 0, 31'h1 << pos[i]);
                chk("R1 latch", m_status, 32'h1 << pos[i]);
                check_all("R1 R7 sweep");
                // R3 clear and event together
                tick(2'd0, 1, 32'h1 << pos[i], 31'h1 << pos[i]);
                check_all("R3 evt wins");
                // R2 clear with zeros elsewhere, then a real clear
                tick(2'd0, 1, ~(32'h1 << pos[i]), 0);
                check_all("R2 zero write");
                tick(2'd0, 1, 32'h1 << pos[i], 0);
                check_all("R2 w1c");
            end
        end

        // R8 undefined positions ignore events and writes
        tick(2'd1, 1, 32'hFFFF_FFFF, 31'h3FFF_FF80);
        rd(2'd1, v); chk("R8 mask holes", v, 32'hC000_007F);
        rd(2'd0, v); chk("R8 status holes", v, 32'h0);
        tick(2'd3, 1, 32'hFFFF_FFFF, 0);
        check_all("R8 offset3 write");
        // R4 R5 zeros leave mask alone
        tick(2'd1, 1, 32'h0, 0);
        check_all("R4 zero set");
        tick(2'd2, 1, 32'h0000_0005, 0);
        check_all("R5 partial clr");

        // mixed sequence against the model
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r1, r2;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            r1 = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            r2 = lfsr;
            tick(r1[1:0], r1[2], r2, (r1[3] ? r1[30:0] & r2[30:0] : 31'h0));
            check_all("R1 R2 R4 R5 mixed");
        end

        // R9 reset again clears everything
        tick(2'd1, 1, 32'hFFFF_FFFF, 31'h7FFF_FFFF);
        @(negedge clk); rst = 1;
        @(posedge clk); #1 rst = 0;
        m_status = 0; m_mask = 0;
        check_all("R9 re-reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule